// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block produces the digital timing for a single successive-approximation conversion, working entirely from the system clock. A start pulse captures the clock prescale value, the sample length, the mode field and the resolution select. The block then walks through five phases in a fixed order: a one-cycle synchronising step into the converter, the sample window, one bit decision per ADC clock, an optional two-clock calibration pass, and a one-cycle synchronising step back out.

While a conversion is running, the block drives an ADC clock whose period is four times (prescale + 1) system clocks. It raises one level output per phase, emits a one-cycle bit-step pulse for each bit decision, holds busy high, and ends with a one-cycle done pulse. The comparator and capacitor array sit outside this block and are clocked by its strobes.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset, busy, done, adcClk, bitStep, adcPowerEn and all five phase outputs are low.
- R2: During the sample, distribution and calibration phases, adcClk has a period of P = 4*(clkDiv+1) system clocks, high for the first half of each period.
- R3: sampleEn is high for exactly (2+sampleLen)*P system clocks per conversion.
- R4: distribPhase is high for N*P system clocks, where N is 8 for resSel=2'b00, 10 for 2'b01, and 12 for 2'b10 and 2'b11.
- R5: bitStep pulses exactly N times per conversion, one system clock each, and only while distribPhase is high.
- R6: When modeIn bit 1 is set, postCalPhase is high for 2*P system clocks after distribution; when it is clear, the calibration phase does not occur.
- R7: syncReadPhase is high for exactly one system clock at the start of a conversion, and syncWritePhase for exactly one at its end; at most one phase output is high at any time.
- R8: A startPulse that arrives while busy is high has no effect on the conversion in progress and does not start a new one.
- R9: busy lasts 2 + sample + distribution + calibration cycles. done is high for exactly one system clock, and busy is low in that same cycle.
- R10: clkDiv, sampleLen, modeIn and resSel are captured in the cycle in which startPulse is accepted; later changes do not alter the running conversion.
- R11: adcPowerEn is high while busy. Once a conversion finishes, it stays high if captured modeIn bit 2 was set and goes low if it was clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a conversion when idle |
| clkDiv | input | 8 | ADC clock prescale value |
| sampleLen | input | 8 | Sample phase extension in ADC clocks |
| modeIn | input | 4 | Mode field; bit 1 enables calibration, bit 2 keeps the converter powered |
| resSel | input | 2 | Resolution select |
| adcClk | output | 1 | Divided ADC clock |
| syncReadPhase | output | 1 | Inbound synchronising phase |
| sampleEn | output | 1 | Sample window active |
| distribPhase | output | 1 | Bit decision phase |
| postCalPhase | output | 1 | Calibration phase |
| syncWritePhase | output | 1 | Outbound synchronising phase |
| bitStep | output | 1 | One pulse per bit decision |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| adcPowerEn | output | 1 | Converter power enable |

## Verification
The hardest situation to reach is a disturbance in the middle of a long phase. Both a second start pulse and new prescale, length and resolution values have to arrive while the sample or distribution counter is partway through, well after the configuration was captured. The driver task waits a chosen number of cycles after the accepted start, then pulses start again and drives different settings. The monitor, meanwhile, still expects every phase length, the ADC clock period and the bit-step count to match the original settings, and checks afterwards that no further conversion begins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNCIN,
    PH_SAMPLE,
    PH_DISTRIB,
    PH_POSTCAL,
    PH_SYNCOUT
  } phase_e;

  typedef struct packed {
    logic   loadCfg;
    logic   clrCnt;
    phase_e phase;
  } ctrl_s;

  function automatic logic [3:0] resBits(input logic [1:0] sel);
    case (sel)
      2'b00:   resBits = 4'd8;
      2'b01:   resBits = 4'd10;
      default: resBits = 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int TVC_W  = 8,
  parameter int STC_W  = 8,
  parameter int MODE_W = 4,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic [TVC_W-1:0]  clkDiv,
  input  logic [STC_W-1:0]  sampleLen,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [RES_W-1:0]  resSel,
  output logic              phaseEnd,
  output logic              adcClk,
  output logic              bitStep,
  output logic              calEnable,
  output logic              keepPowered
);

  localparam int DIV_W = TVC_W + 2;
  localparam int CNT_W = (STC_W + 1 > 4) ? STC_W + 1 : 4;

  logic [TVC_W-1:0]  tvcQ;
  logic [STC_W-1:0]  stcQ;
  logic [MODE_W-1:0] modeQ;
  logic [RES_W-1:0]  resQ;
  logic [DIV_W-1:0]  divCnt;
  logic [CNT_W-1:0]  phCnt;
  logic [DIV_W-1:0]  lastDiv;
  logic [DIV_W-1:0]  halfDiv;
  logic [CNT_W-1:0]  phLimit;
  logic [CNT_W-1:0]  lastPh;
  logic              timed;
  logic              adcTick;
  logic              unusedModeBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tvcQ  <= '0;
      stcQ  <= '0;
      modeQ <= '0;
      resQ  <= '0;
    end else if (ctrl.loadCfg) begin
      tvcQ  <= clkDiv;
      stcQ  <= sampleLen;
      modeQ <= modeIn;
      resQ  <= resSel;
    end
  end

  assign lastDiv = {tvcQ, 2'b11};
  assign halfDiv = {1'b0, tvcQ, 1'b0} + DIV_W'(2);
  assign timed   = (ctrl.phase == PH_SAMPLE) || (ctrl.phase == PH_DISTRIB) ||
                   (ctrl.phase == PH_POSTCAL);

  always_comb begin
    case (ctrl.phase)
      PH_SAMPLE:  phLimit = CNT_W'(stcQ) + CNT_W'(2);
      PH_DISTRIB: phLimit = CNT_W'(resBits(resQ[1:0]));
      PH_POSTCAL: phLimit = CNT_W'(2);
      default:    phLimit = CNT_W'(1);
    endcase
  end
  assign lastPh = phLimit - CNT_W'(1);

  assign adcTick  = timed && (divCnt == lastDiv);
  assign phaseEnd = timed ? (adcTick && (phCnt == lastPh)) : 1'b1;
  assign bitStep  = adcTick && (ctrl.phase == PH_DISTRIB);
  assign adcClk   = timed && (divCnt < halfDiv);

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clrCnt) begin
      divCnt <= '0;
      phCnt  <= '0;
    end else begin
      divCnt <= adcTick ? '0 : divCnt + DIV_W'(1);
      if (adcTick) phCnt <= (phCnt == lastPh) ? '0 : phCnt + CNT_W'(1);
    end
  end

  assign calEnable      = modeQ[1];
  assign keepPowered    = modeQ[2];
  assign unusedModeBits = ^{modeQ[MODE_W-1], modeQ[0]};

  // ADC divider never passes the end of its period
  assert_div_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    divCnt <= lastDiv);

  // Captured settings hold for the whole conversion
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.phase != PH_IDLE) |=> ($stable(tvcQ) && $stable(stcQ) &&
                                 $stable(resQ) && $stable(modeQ)));

  // Phase counter stays below the active phase length
  assert_phase_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    timed |-> (phCnt <= lastPh));

endmodule

// File: rtl/adc_seq_control.sv
module adc_seq_control
  import adc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startPulse,
  input  logic  phaseEnd,
  input  logic  calEnable,
  input  logic  keepPowered,
  output ctrl_s ctrl,
  output logic  syncReadPhase,
  output logic  sampleEn,
  output logic  distribPhase,
  output logic  postCalPhase,
  output logic  syncWritePhase,
  output logic  busy,
  output logic  done,
  output logic  adcPowerEn
);

  phase_e state;
  phase_e nextState;
  logic   doneQ;

  always_comb begin
    nextState = state;
    case (state)
      PH_IDLE:    if (startPulse) nextState = PH_SYNCIN;
      PH_SYNCIN:  nextState = PH_SAMPLE;
      PH_SAMPLE:  if (phaseEnd) nextState = PH_DISTRIB;
      PH_DISTRIB: if (phaseEnd) nextState = calEnable ? PH_POSTCAL : PH_SYNCOUT;
      PH_POSTCAL: if (phaseEnd) nextState = PH_SYNCOUT;
      PH_SYNCOUT: nextState = PH_IDLE;
      default:    nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= (state == PH_SYNCOUT);
    end
  end

  assign ctrl.loadCfg = (state == PH_IDLE) && startPulse;
  assign ctrl.clrCnt  = (state == PH_IDLE) || (state == PH_SYNCIN) ||
                        (state == PH_SYNCOUT);
  assign ctrl.phase   = state;

  assign syncReadPhase  = (state == PH_SYNCIN);
  assign sampleEn       = (state == PH_SAMPLE);
  assign distribPhase   = (state == PH_DISTRIB);
  assign postCalPhase   = (state == PH_POSTCAL);
  assign syncWritePhase = (state == PH_SYNCOUT);
  assign busy           = (state != PH_IDLE);
  assign done           = doneQ;
  assign adcPowerEn     = busy || keepPowered;

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_phase_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({syncReadPhase, sampleEn, distribPhase, postCalPhase, syncWritePhase}));

  assert_sync_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    syncReadPhase |=> sampleEn);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !syncWritePhase && startPulse) |=> !syncReadPhase);

  assert_power_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> adcPowerEn);

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int TVC_W  = 8,
  parameter int STC_W  = 8,
  parameter int MODE_W = 4,
  parameter int RES_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [TVC_W-1:0]  clkDiv,
  input  logic [STC_W-1:0]  sampleLen,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [RES_W-1:0]  resSel,
  output logic              adcClk,
  output logic              syncReadPhase,
  output logic              sampleEn,
  output logic              distribPhase,
  output logic              postCalPhase,
  output logic              syncWritePhase,
  output logic              bitStep,
  output logic              busy,
  output logic              done,
  output logic              adcPowerEn
);

  ctrl_s ctrl;
  logic  phaseEnd;
  logic  calEnable;
  logic  keepPowered;

  adc_seq_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .startPulse     (startPulse),
    .phaseEnd       (phaseEnd),
    .calEnable      (calEnable),
    .keepPowered    (keepPowered),
    .ctrl           (ctrl),
    .syncReadPhase  (syncReadPhase),
    .sampleEn       (sampleEn),
    .distribPhase   (distribPhase),
    .postCalPhase   (postCalPhase),
    .syncWritePhase (syncWritePhase),
    .busy           (busy),
    .done           (done),
    .adcPowerEn     (adcPowerEn)
  );

  adc_seq_datapath #(
    .TVC_W  (TVC_W),
    .STC_W  (STC_W),
    .MODE_W (MODE_W),
    .RES_W  (RES_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .clkDiv      (clkDiv),
    .sampleLen   (sampleLen),
    .modeIn      (modeIn),
    .resSel      (resSel),
    .phaseEnd    (phaseEnd),
    .adcClk      (adcClk),
    .bitStep     (bitStep),
    .calEnable   (calEnable),
    .keepPowered (keepPowered)
  );

endmodule

// File: tb/adc_conv_sequencer_bench.sv
`timescale 1ns/1ps
module adc_conv_sequencer_bench;

  typedef struct {
    int sampleCyc;
    int distCyc;
    int calCyc;
    int bitSteps;
    int busyCyc;
    int period;
    bit power;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [7:0] clkDiv = '0;
  logic [7:0] sampleLen = '0;
  logic [3:0] modeIn = '0;
  logic [1:0] resSel = '0;
  logic adcClk, syncReadPhase, sampleEn, distribPhase, postCalPhase;
  logic syncWritePhase, bitStep, busy, done, adcPowerEn;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int convDone = 0;
  exp_t expQ[$];

  always #2 clk = ~clk;

  adc_conv_sequencer u_adc_conv_sequencer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .clkDiv(clkDiv),
    .sampleLen(sampleLen), .modeIn(modeIn), .resSel(resSel), .adcClk(adcClk),
    .syncReadPhase(syncReadPhase), .sampleEn(sampleEn), .distribPhase(distribPhase),
    .postCalPhase(postCalPhase), .syncWritePhase(syncWritePhase), .bitStep(bitStep),
    .busy(busy), .done(done), .adcPowerEn(adcPowerEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: accumulates per-conversion counts and compares at done
  int cSync, cSamp, cDist, cCal, cWr, cStep, cBusy, badPeriod, lastRise;
  logic prevClk = 1'b0;
  logic doneSeen = 1'b0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finishRun();
    end
    if (rstN) begin
      if (doneSeen) check(!done, "R9 done width", done, 0);
      doneSeen = done;
      if (busy) begin
        cBusy++;
        if (syncReadPhase) cSync++;
        if (sampleEn) cSamp++;
        if (distribPhase) cDist++;
        if (postCalPhase) cCal++;
        if (syncWritePhase) cWr++;
        if (bitStep) begin
          cStep++;
          if (!distribPhase) badPeriod++;
        end
        if (adcClk && !prevClk) begin
          if (lastRise >= 0 && expQ.size() > 0 && (cBusy - lastRise) != expQ[0].period)
            badPeriod++;
          lastRise = cBusy;
        end
      end
      prevClk = adcClk;
      if (done) begin
        exp_t e;
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected conversion", 1, 0);
        end else begin
          e = expQ.pop_front();
          check(!busy, "R9 busy low with done", busy, 0);
          check(cBusy == e.busyCyc, "R9 busy length", cBusy, e.busyCyc);
          check(cSync == 1 && cWr == 1, "R7 sync phases", cSync * 10 + cWr, 11);
          check(cSamp == e.sampleCyc, "R3 sample length", cSamp, e.sampleCyc);
          check(cDist == e.distCyc, "R4 distribution length", cDist, e.distCyc);
          check(cStep == e.bitSteps, "R5 bit steps", cStep, e.bitSteps);
          check(cCal == e.calCyc, "R6 calibration length", cCal, e.calCyc);
          check(badPeriod == 0, "R2 adc clock period", badPeriod, 0);
          check(adcPowerEn == e.power, "R11 power after done", adcPowerEn, e.power);
        end
        convDone++;
        cSync = 0; cSamp = 0; cDist = 0; cCal = 0; cWr = 0; cStep = 0;
        cBusy = 0; badPeriod = 0; lastRise = -1;
      end
    end
  end

  // Driver: starts a conversion and pushes its expected item
  task automatic runConv(input int tvc, input int stc, input int mode, input int res,
                         input int disturbAt);
    exp_t e;
    int n;
    int target;
    n = (res == 0) ? 8 : (res == 1) ? 10 : 12;
    e.period    = 4 * (tvc + 1);
    e.sampleCyc = (2 + stc) * e.period;
    e.distCyc   = n * e.period;
    e.calCyc    = mode[1] ? 2 * e.period : 0;
    e.bitSteps  = n;
    e.busyCyc   = 2 + e.sampleCyc + e.distCyc + e.calCyc;
    e.power     = mode[2];
    target = convDone + 1;
    expQ.push_back(e);
    @(negedge clk);
    clkDiv = 8'(tvc); sampleLen = 8'(stc); modeIn = 4'(mode); resSel = 2'(res);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (disturbAt > 0) begin
      repeat (disturbAt) @(negedge clk);
      // R8 / R10: second start and new settings mid-conversion
      startPulse = 1'b1;
      clkDiv = 8'(tvc + 3); sampleLen = 8'(stc + 5); modeIn = ~4'(mode); resSel = 2'(res + 1);
      @(negedge clk);
      startPulse = 1'b0;
    end
    while (convDone < target) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!busy, "R8 no restart after done", busy, 0);
    check(adcPowerEn == e.power, "R11 power held", adcPowerEn, e.power);
  endtask

  initial begin
    lastRise = -1;
    cSync = 0; cSamp = 0; cDist = 0; cCal = 0; cWr = 0; cStep = 0;
    cBusy = 0; badPeriod = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({busy, done, adcClk, bitStep, adcPowerEn, syncReadPhase, sampleEn,
           distribPhase, postCalPhase, syncWritePhase} == '0, "R1 reset outputs",
          {busy, done, adcPowerEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !adcPowerEn, "R1 idle after reset", busy, 0);
    runConv(0, 0, 4'b0000, 0, 0);
    runConv(1, 3, 4'b0100, 1, 0);
    runConv(1, 3, 4'b0110, 1, 0);
    runConv(2, 1, 4'b0010, 2, 0);
    runConv(0, 2, 4'b0100, 3, 0);
    runConv(1, 4, 4'b0010, 1, 20);
    runConv(2, 0, 4'b0000, 0, 70);
    runConv(5, 1, 4'b0110, 2, 10);
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9 all conversions completed", expQ.size(), 0);
    finishRun();
  end

endmodule